// File: doc/BRIEF.md
# Single-Lane Vector Bit-Manipulation Unit

This unit takes one vector element per operation and applies one of four unary bit operations to it: reversal of the whole element, a leading-zero count, a trailing-zero count, or a count of set bits. The element sits zero-extended on a 64-bit operand bus. An element-width select confines the operation to 8, 16, 32 or 64 bits. Every count and the reversal respect that field, including an element that is entirely zero.

The caller steps through the elements. It applies masking and handles register-file reads and writes. For each element it presents the operand, an opcode and the width select together with a valid strobe. One clock later the unit returns a 64-bit result and a matching valid strobe. The result holds a value as wide as the element, and every bit above the element is zero.

A two-state output sequencer sets the timing. `ST_IDLE` means no result is pending. `ST_ISSUE` means a result was captured on the last edge. The sequencer takes transition `T_ACCEPT` from either state to `ST_ISSUE` when the input strobe is high. It takes transition `T_DRAIN` from either state to `ST_IDLE` when the strobe is low. Synchronous reset forces `ST_IDLE`.

Top module: `vbm_unit`

## Requirements
- R1: `out_valid_o` is high in the cycle after an edge that samples `in_valid_i` high, and low after an edge that samples it low. A synchronous active-high `rst_i` forces `out_valid_o` low. The result is presented together with `out_valid_o`.
- R2: Opcode `2'b00` reverses the element, so field bit j moves to bit SEW-1-j. For SEW above 8 this also inverts the order of the bytes.
- R3: Opcode `2'b01` returns the number of zero bits above the highest set bit, counted from bit SEW-1 downward. Zero bits above the field are not counted.
- R4: Opcode `2'b01` on an element whose SEW-wide field is all zero returns SEW, not 64.
- R5: Opcode `2'b10` returns the number of zero bits below the lowest set bit of the field.
- R6: Opcode `2'b10` on an all-zero field returns SEW, not 64.
- R7: Opcode `2'b11` returns the number of set bits in the field, a value from 0 to SEW inclusive.
- R8: The width select `in_sew_i` encodes `2'b00`=8, `2'b01`=16, `2'b10`=32 and `2'b11`=64 bits. Operand bits at position SEW and above have no effect on any result.
- R9: Result bits at position SEW and above are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| in_valid_i | input | 1 | Operation request strobe |
| in_op_i | input | 2 | Operation select: 00 reverse, 01 leading zeros, 10 trailing zeros, 11 set-bit count |
| in_sew_i | input | 2 | Element width select: 00=8, 01=16, 10=32, 11=64 |
| in_operand_i | input | 64 | Zero-extended element |
| out_valid_o | output | 1 | Result strobe, one clock after the request |
| out_result_o | output | 64 | SEW-wide result, zero above the field |

## Verification
The bench tries each operation at every width with four kinds of operand: a single set bit at the bottom of the field, a single set bit at the top, an all-zero field, and an all-ones field.

- The single-bit cases separate a count taken over the element width from one taken over 64 bits.
- The all-zero cases isolate the rule that returns SEW for both zero counts.
- The all-ones cases check the maximum set-bit count and reversal of the full width.

Asymmetric patterns such as `0x0102` show whether the reversal inverts the byte order or only flips bits inside each byte. Operands carrying ones above the field show whether those bits leak into any result. Back-to-back and gapped strobes, plus a strobe held during reset, exercise the sequencer transitions.

// File: rtl/vbm_pkg.sv
package vbm_pkg;

    localparam int NUM_SEW = 4;

    typedef enum logic [1:0] {
        OP_REV = 2'b00,
        OP_CLZ = 2'b01,
        OP_CTZ = 2'b10,
        OP_POP = 2'b11
    } vbm_op_e;

    typedef enum logic [1:0] {
        SEW_8  = 2'b00,
        SEW_16 = 2'b01,
        SEW_32 = 2'b10,
        SEW_64 = 2'b11
    } vbm_sew_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_ISSUE = 1'b1
    } vbm_state_e;

endpackage

// File: rtl/vbm_field_mask.sv
module vbm_field_mask #(
    parameter int DATA_W = 64
) (
    input  logic [1:0]        sew_i,
    input  logic [DATA_W-1:0] operand_i,
    output logic [DATA_W-1:0] field_o
);
    localparam int IDX_W = $clog2(DATA_W) + 1;

    logic [IDX_W-1:0] width_bits;

    always_comb begin
        width_bits = IDX_W'(32'd8 << sew_i);
        for (int b = 0; b < DATA_W; b++) begin
            field_o[b] = operand_i[b] & (IDX_W'(b) < width_bits);
        end
    end
endmodule

// File: rtl/vbm_reverse.sv
module vbm_reverse #(
    parameter int DATA_W  = 64,
    parameter int NUM_SEW = 4
) (
    input  logic [1:0]        sew_i,
    input  logic [DATA_W-1:0] field_i,
    output logic [DATA_W-1:0] rev_o
);
    logic [NUM_SEW-1:0][DATA_W-1:0] cand;

    for (genvar k = 0; k < NUM_SEW; k++) begin : g_width
        localparam int W = 8 << k;
        for (genvar b = 0; b < DATA_W; b++) begin : g_bit
            if (b < W) begin : g_in
                assign cand[k][b] = field_i[W-1-b];
            end else begin : g_out
                assign cand[k][b] = 1'b0;
            end
        end
    end

    assign rev_o = cand[sew_i];
endmodule

// File: rtl/vbm_count.sv
module vbm_count #(
    parameter int DATA_W = 64,
    parameter int CNT_W  = 7
) (
    input  logic [1:0]        sew_i,
    input  logic [DATA_W-1:0] field_i,
    input  logic [DATA_W-1:0] rev_i,
    output logic [CNT_W-1:0]  clz_o,
    output logic [CNT_W-1:0]  ctz_o,
    output logic [CNT_W-1:0]  pop_o
);
    logic [CNT_W-1:0] width_cnt;

    function automatic logic [CNT_W-1:0] low_zero_run(
        input logic [DATA_W-1:0] v,
        input logic [CNT_W-1:0]  empty_val
    );
        logic [CNT_W-1:0] n;
        n = empty_val;
        for (int i = DATA_W - 1; i >= 0; i--) begin
            if (v[i]) n = CNT_W'(i);
        end
        return n;
    endfunction

    always_comb begin
        width_cnt = CNT_W'(32'd8 << sew_i);
        ctz_o     = low_zero_run(field_i, width_cnt);
        clz_o     = low_zero_run(rev_i, width_cnt);
        pop_o     = '0;
        for (int i = 0; i < DATA_W; i++) begin
            pop_o = pop_o + CNT_W'(field_i[i]);
        end
    end
endmodule

// File: rtl/vbm_unit.sv
module vbm_unit
    import vbm_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              in_valid_i,
    input  logic [1:0]        in_op_i,
    input  logic [1:0]        in_sew_i,
    input  logic [DATA_W-1:0] in_operand_i,
    output logic              out_valid_o,
    output logic [DATA_W-1:0] out_result_o
);
    localparam int CNT_W = $clog2(DATA_W) + 1;

    vbm_state_e       state_q, state_d;
    logic [DATA_W-1:0] field, rev, result_d, result_q;
    logic [CNT_W-1:0]  clz, ctz, pop;

    vbm_field_mask #(.DATA_W(DATA_W)) i_mask (
        .sew_i     (in_sew_i),
        .operand_i (in_operand_i),
        .field_o   (field)
    );

    vbm_reverse #(.DATA_W(DATA_W), .NUM_SEW(NUM_SEW)) i_rev (
        .sew_i   (in_sew_i),
        .field_i (field),
        .rev_o   (rev)
    );

    vbm_count #(.DATA_W(DATA_W), .CNT_W(CNT_W)) i_cnt (
        .sew_i   (in_sew_i),
        .field_i (field),
        .rev_i   (rev),
        .clz_o   (clz),
        .ctz_o   (ctz),
        .pop_o   (pop)
    );

    always_comb begin
        unique case (vbm_op_e'(in_op_i))
            OP_REV:  result_d = rev;
            OP_CLZ:  result_d = DATA_W'(clz);
            OP_CTZ:  result_d = DATA_W'(ctz);
            OP_POP:  result_d = DATA_W'(pop);
            default: result_d = '0;
        endcase
    end

    // next state: T_ACCEPT / T_DRAIN
    always_comb begin
        unique case (state_q)
            ST_IDLE:  state_d = in_valid_i ? ST_ISSUE : ST_IDLE;
            ST_ISSUE: state_d = in_valid_i ? ST_ISSUE : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) state_q <= ST_IDLE;
        else       state_q <= state_d;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i)           result_q <= '0;
        else if (in_valid_i) result_q <= result_d;
    end

    assign out_valid_o  = (state_q == ST_ISSUE);
    assign out_result_o = result_q;
endmodule

// File: rtl/vbm_unit_chk.sv
module vbm_unit_chk #(
    parameter int DATA_W = 64
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic              in_valid_i,
    input logic [1:0]        in_op_i,
    input logic [1:0]        in_sew_i,
    input logic [DATA_W-1:0] in_operand_i,
    input logic              out_valid_o,
    input logic [DATA_W-1:0] out_result_o
);
    a_r1_valid_follows: assert property (@(posedge clk_i) disable iff (rst_i)
        in_valid_i |=> out_valid_o);

    a_r1_valid_drops: assert property (@(posedge clk_i) disable iff (rst_i)
        !in_valid_i |=> !out_valid_o);

    a_r9_upper_zero_8: assert property (@(posedge clk_i) disable iff (rst_i)
        (out_valid_o && $past(in_sew_i) == 2'b00) |-> out_result_o[DATA_W-1:8] == '0);

    a_r9_upper_zero_16: assert property (@(posedge clk_i) disable iff (rst_i)
        (out_valid_o && $past(in_sew_i) == 2'b01) |-> out_result_o[DATA_W-1:16] == '0);

    a_r9_upper_zero_32: assert property (@(posedge clk_i) disable iff (rst_i)
        (out_valid_o && $past(in_sew_i) == 2'b10) |-> out_result_o[DATA_W-1:32] == '0);

    a_r7_pop_bound: assert property (@(posedge clk_i) disable iff (rst_i)
        (out_valid_o && $past(in_op_i) == 2'b11)
        |-> out_result_o <= (DATA_W'(8) << $past(in_sew_i)));

    a_r4_clz_all_zero: assert property (@(posedge clk_i) disable iff (rst_i)
        (out_valid_o && $past(in_op_i) == 2'b01 && $past(in_sew_i) == 2'b11
         && $past(in_operand_i) == '0) |-> out_result_o == DATA_W'(64));

    a_r6_ctz_all_zero: assert property (@(posedge clk_i) disable iff (rst_i)
        (out_valid_o && $past(in_op_i) == 2'b10 && $past(in_sew_i) == 2'b00
         && $past(in_operand_i[7:0]) == 8'h00) |-> out_result_o == DATA_W'(8));
endmodule

bind vbm_unit vbm_unit_chk #(.DATA_W(DATA_W)) i_vbm_unit_chk (.*);

// File: tb/test_vbm_unit.sv
module test_vbm_unit;
    logic        clk = 1'b0;
    logic        rst_i = 1'b1;
    logic        in_valid_i = 1'b0;
    logic [1:0]  in_op_i = 2'b00;
    logic [1:0]  in_sew_i = 2'b00;
    logic [63:0] in_operand_i = '0;
    logic        out_valid_o;
    logic [63:0] out_result_o;
    int          n_tests = 0;
    int          n_fail = 0;

    always #5 clk = ~clk;

    vbm_unit i_vbm_unit (
        .clk_i        (clk),
        .rst_i        (rst_i),
        .in_valid_i   (in_valid_i),
        .in_op_i      (in_op_i),
        .in_sew_i     (in_sew_i),
        .in_operand_i (in_operand_i),
        .out_valid_o  (out_valid_o),
        .out_result_o (out_result_o)
    );

    function automatic int wbits(logic [1:0] s);
        return 8 << s;
    endfunction

    function automatic logic [63:0] m_field(logic [63:0] x, logic [1:0] s);
        logic [63:0] f = '0;
        for (int j = 0; j < wbits(s); j++) f[j] = x[j];
        return f;
    endfunction

    function automatic logic [63:0] model(logic [1:0] op, logic [1:0] s, logic [63:0] x);
        logic [63:0] f = m_field(x, s);
        logic [63:0] r = '0;
        int n = 0;
        case (op)
            2'b00: for (int j = 0; j < wbits(s); j++) r = {r[62:0], f[j]};
            2'b01: begin
                for (int j = wbits(s) - 1; j >= 0; j--) begin
                    if (f[j]) break;
                    n++;
                end
                r = 64'(n);
            end
            2'b10: begin
                while (n < wbits(s) && !f[n]) n++;
                r = 64'(n);
            end
            default: begin
                for (int j = 0; j < 64; j++) n += int'(f[j]);
                r = 64'(n);
            end
        endcase
        return r;
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // drive one request at a falling edge, check at the next falling edge
    task automatic run_op(string req, logic [1:0] op, logic [1:0] s, logic [63:0] x);
        @(negedge clk);
        in_valid_i = 1'b1; in_op_i = op; in_sew_i = s; in_operand_i = x;
        @(negedge clk);
        in_valid_i = 1'b0;
        check({req, " valid"}, 64'(out_valid_o), 64'd1);
        check(req, out_result_o, model(op, s, x));
    endtask

    task automatic t_reset();
        @(negedge clk);
        in_valid_i = 1'b1;
        @(negedge clk);
        check("R1 reset valid", 64'(out_valid_o), 64'd0);
        in_valid_i = 1'b0;
        rst_i = 1'b0;
        @(negedge clk);
        check("R1 idle after reset", 64'(out_valid_o), 64'd0);
    endtask

    task automatic t_reverse();
        run_op("R2 rev8", 2'b00, 2'b00, 64'h01);
        check("R2 rev8 literal", out_result_o, 64'h80);
        run_op("R2 rev16 bytes", 2'b00, 2'b01, 64'h0102);
        check("R2 rev16 literal", out_result_o, 64'h4080);
        run_op("R2 rev32", 2'b00, 2'b10, 64'h1234_5678);
        run_op("R2 rev64", 2'b00, 2'b11, 64'h0000_0000_0000_0001);
        check("R2 rev64 literal", out_result_o, 64'h8000_0000_0000_0000);
        run_op("R2 rev64 ones", 2'b00, 2'b11, '1);
    endtask

    task automatic t_clz();
        for (int s = 0; s < 4; s++) begin
            run_op("R3 clz low bit", 2'b01, 2'(s), 64'h1);
            run_op("R3 clz top bit", 2'b01, 2'(s), 64'h1 << (wbits(2'(s)) - 1));
            run_op("R4 clz zero", 2'b01, 2'(s), 64'h0);
        end
        check("R4 clz zero sew64 literal", out_result_o, 64'd64);
        run_op("R3 clz sew16", 2'b01, 2'b01, 64'h00F0);
        check("R3 clz sew16 literal", out_result_o, 64'd8);
    endtask

    task automatic t_ctz();
        for (int s = 0; s < 4; s++) begin
            run_op("R5 ctz top bit", 2'b10, 2'(s), 64'h1 << (wbits(2'(s)) - 1));
            run_op("R6 ctz zero", 2'b10, 2'(s), 64'h0);
        end
        run_op("R6 ctz zero sew8", 2'b10, 2'b00, 64'h0);
        check("R6 ctz zero sew8 literal", out_result_o, 64'd8);
        run_op("R5 ctz mid", 2'b10, 2'b10, 64'h0010_0000);
        check("R5 ctz mid literal", out_result_o, 64'd20);
    endtask

    task automatic t_pop();
        for (int s = 0; s < 4; s++) begin
            run_op("R7 pop ones", 2'b11, 2'(s), '1);
            run_op("R7 pop zero", 2'b11, 2'(s), 64'h0);
        end
        check("R7 pop zero literal", out_result_o, 64'd0);
        run_op("R7 pop ones64", 2'b11, 2'b11, '1);
        check("R7 pop ones64 literal", out_result_o, 64'd64);
        run_op("R7 pop alt", 2'b11, 2'b10, 64'h5555_5555);
    endtask

    task automatic t_upper_ignored();
        run_op("R8 clz junk above", 2'b01, 2'b00, 64'hFFFF_FFFF_FFFF_FF00);
        check("R8 clz junk literal", out_result_o, 64'd8);
        run_op("R8 pop junk above", 2'b11, 2'b01, 64'hABCD_0000_0000_0003);
        check("R8 pop junk literal", out_result_o, 64'd2);
        run_op("R9 rev junk above", 2'b00, 2'b10, 64'hFFFF_FFFF_0000_0001);
        check("R9 rev upper literal", out_result_o, 64'h8000_0000);
        run_op("R8 ctz junk above", 2'b10, 2'b01, 64'hFFFF_0000);
        check("R8 ctz junk literal", out_result_o, 64'd16);
    endtask

    task automatic t_valid_timing();
        @(negedge clk);
        in_valid_i = 1'b1; in_op_i = 2'b11; in_sew_i = 2'b00; in_operand_i = 64'h3;
        @(negedge clk);
        check("R1 first of pair valid", 64'(out_valid_o), 64'd1);
        check("R1 first of pair", out_result_o, 64'd2);
        in_operand_i = 64'h7;
        @(negedge clk);
        in_valid_i = 1'b0;
        check("R1 second of pair valid", 64'(out_valid_o), 64'd1);
        check("R1 second of pair", out_result_o, 64'd3);
        @(negedge clk);
        check("R1 gap valid", 64'(out_valid_o), 64'd0);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        check("R1 reset state", 64'(out_valid_o), 64'd0);
        t_reset();
        t_reverse();
        t_clz();
        t_ctz();
        t_pop();
        t_upper_ignored();
        t_valid_timing();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog act=hung exp=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule